// File: doc/BRIEF.md
# Address Breakpoint and Watchpoint Unit

This unit sits beside a processor core and watches two streams of addresses: the data bus (reads and writes) and the instruction fetch address. It holds two comparison addresses and a small control word. When an access of an enabled kind hits one of the addresses, the unit sets a sticky hit flag for that address. While the unit is armed, any set flag raises a halt request to the core. A debug agent configures the unit and clears the flags through a four-entry register interface.

An optional range mode is chosen at build time. In this mode, any enabled access whose address lies between the two comparison addresses, bounds included, sets both flags. Comparison uses word addresses, so a byte access to either half of a watched word hits.

All pins are plain control and status pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. A register write takes effect on the clock edge where `reg_wr` is high. An access is sampled on every edge where its strobe is high.

Top module: `brk_watch_unit`

## Requirements
- R1: After reset, all four registers read 0, `hit_flags` is 0 and `halt_req` is low.
- R2: `reg_sel` picks the register: 0 is control, 1 is hit status, 2 is address A, 3 is address B. A write shows on `reg_rdata` from the next cycle. Control bits above bit 4 read 0.
- R3: Data reads are matched when control bit 0 (reads) and bit 2 (arm) are set. A read at address A sets status bit 0, and a read at address B sets status bit 1, on the edge that samples the access. Other access kinds do not match under this bit.
- R4: Data writes are matched when control bit 1 and bit 2 are set, with the same flag mapping as R3. A read does not match under bit 1.
- R5: Instruction fetches (`fetch_vld`, `fetch_addr`) are matched when control bit 3 and bit 2 are set. A data access does not match under bit 3.
- R6: Matching ignores address bit 0 on both the data and fetch paths.
- R7: While control bit 2 is clear, no access sets a flag.
- R8: When range support is built in and control bit 4 is set, a qualified access hits when its word address is at or above address A and at or below address B. Such a hit sets both status bits. An access outside the range sets nothing, and the exact-match rule is not applied.
- R9: When range support is built out (`RANGE_EN`=0), control bit 4 reads back 0 and exact matching applies whatever value is written to that bit.
- R10: Flags stay set until a status write with 1 in the flag's bit position. Bits written as 0 leave their flags unchanged. A hit in the same cycle as a clear leaves the flag set.
- R11: `halt_req` is high exactly when control bit 2 is set and at least one flag is set. Disarming drops the request but keeps the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Read data of the selected register (combinational) |
| bus_rd | input | 1 | Data read strobe |
| bus_wr | input | 1 | Data write strobe |
| bus_addr | input | ADDR_W | Data access byte address |
| fetch_vld | input | 1 | Instruction fetch strobe |
| fetch_addr | input | ADDR_W | Instruction fetch byte address |
| hit_flags | output | 2 | Sticky hit flags: bit 0 for address A, bit 1 for address B |
| halt_req | output | 1 | Halt request to the core |

## Verification
The bench builds two copies that share every input. Both use a 16-bit address. One has `RANGE_EN`=1 and the other has `RANGE_EN`=0. Because the inputs are shared, one stimulus shows both behaviours of the range bit in the same cycle. Range-mode hits at both inclusive bounds and just outside them are set against the exact-match result of the copy without range support. This includes an odd address one byte above the upper bound, which reaches the word-address rule from R6.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int NUM_SLOT = 2;
  localparam int CTRL_W   = 5;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_LO   = 2'd2,
    SEL_HI   = 2'd3
  } reg_sel_e;

  // packed from bit 4 down to bit 0
  typedef struct packed {
    logic rng;
    logic fetch;
    logic arm;
    logic wr;
    logic rd;
  } brk_ctrl_t;
endpackage

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int RANGE_EN = 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               reg_wr,
  input  logic [1:0]                         reg_sel,
  input  logic [ADDR_W-1:0]                  reg_wdata,
  output brk_ctrl_t                          ctrl_q,
  output logic [NUM_SLOT-1:0][ADDR_W-1:0]    slot_addr_q
);
  localparam bit RNG_OK = (RANGE_EN != 0);

  logic ctrl_we;
  assign ctrl_we = reg_wr && (reg_sel == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q.rd    <= reg_wdata[0];
      ctrl_q.wr    <= reg_wdata[1];
      ctrl_q.arm   <= reg_wdata[2];
      ctrl_q.fetch <= reg_wdata[3];
      ctrl_q.rng   <= RNG_OK ? reg_wdata[4] : 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot
    logic slot_we;
    assign slot_we = reg_wr && (reg_sel == (SEL_LO + 2'(i)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_addr_q[i] <= '0;
      else if (slot_we) slot_addr_q[i] <= reg_wdata;
    end
  end
endmodule

// File: rtl/brk_match.sv
module brk_match
  import brk_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int RANGE_EN = 1
) (
  input  brk_ctrl_t                       ctrl,
  input  logic [NUM_SLOT-1:0][ADDR_W-1:0] slot_addr,
  input  logic                            bus_rd,
  input  logic                            bus_wr,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic                            fetch_vld,
  input  logic [ADDR_W-1:0]               fetch_addr,
  output logic [NUM_SLOT-1:0]             hit_set
);
  localparam int WA_W = ADDR_W - 1;

  logic [WA_W-1:0] bus_wa, fetch_wa;
  logic            data_q, fetch_q;
  logic [NUM_SLOT-1:0] exact_hit;
  logic            range_hit;

  assign bus_wa   = bus_addr[ADDR_W-1:1];
  assign fetch_wa = fetch_addr[ADDR_W-1:1];
  assign data_q   = (ctrl.rd & bus_rd) | (ctrl.wr & bus_wr);
  assign fetch_q  = ctrl.fetch & fetch_vld;

  for (genvar i = 0; i < NUM_SLOT; i++) begin : g_cmp
    logic [WA_W-1:0] slot_wa;
    assign slot_wa = slot_addr[i][ADDR_W-1:1];
    assign exact_hit[i] = ctrl.arm & ~ctrl.rng &
                          ((data_q  & (bus_wa   == slot_wa)) |
                           (fetch_q & (fetch_wa == slot_wa)));
  end

  if (RANGE_EN != 0) begin : g_range
    logic [WA_W-1:0] lo_wa, hi_wa;
    logic            bus_in, fetch_in;
    assign lo_wa    = slot_addr[0][ADDR_W-1:1];
    assign hi_wa    = slot_addr[1][ADDR_W-1:1];
    assign bus_in   = (bus_wa   >= lo_wa) && (bus_wa   <= hi_wa);
    assign fetch_in = (fetch_wa >= lo_wa) && (fetch_wa <= hi_wa);
    assign range_hit = ctrl.arm & ctrl.rng &
                       ((data_q & bus_in) | (fetch_q & fetch_in));
  end else begin : g_no_range
    assign range_hit = 1'b0;
  end

  assign hit_set = exact_hit | {NUM_SLOT{range_hit}};

  logic unused_lsb;
  assign unused_lsb = ^{bus_addr[0], fetch_addr[0], slot_addr[0][0], slot_addr[1][0]};
endmodule

// File: rtl/brk_pend.sv
module brk_pend #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= set_i | (pend_q & ~clr_i);
  end
endmodule

// File: rtl/brk_watch_unit.sv
module brk_watch_unit
  import brk_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int RANGE_EN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              fetch_vld,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [1:0]        hit_flags,
  output logic              halt_req
);
  brk_ctrl_t                       ctrl_q;
  logic [NUM_SLOT-1:0][ADDR_W-1:0] slot_addr_q;
  logic [NUM_SLOT-1:0]             hit_set, hit_clr, pend_q;

  brk_regs #(.ADDR_W(ADDR_W), .RANGE_EN(RANGE_EN)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_q(ctrl_q), .slot_addr_q(slot_addr_q)
  );

  brk_match #(.ADDR_W(ADDR_W), .RANGE_EN(RANGE_EN)) u_match (
    .ctrl(ctrl_q), .slot_addr(slot_addr_q), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
    .hit_set(hit_set)
  );

  assign hit_clr = (reg_wr && (reg_sel == SEL_STAT)) ? reg_wdata[NUM_SLOT-1:0] : '0;

  brk_pend #(.N(NUM_SLOT)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(hit_set), .clr_i(hit_clr), .pend_q(pend_q)
  );

  always_comb begin
    unique case (reg_sel)
      SEL_CTRL: reg_rdata = ADDR_W'(ctrl_q);
      SEL_STAT: reg_rdata = ADDR_W'(pend_q);
      SEL_LO:   reg_rdata = slot_addr_q[0];
      default:  reg_rdata = slot_addr_q[1];
    endcase
  end

  assign hit_flags = pend_q;
  assign halt_req  = ctrl_q.arm & (|pend_q);
endmodule

// File: rtl/brk_watch_chk.sv
module brk_watch_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic [ADDR_W-1:0] reg_wdata,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              fetch_vld,
  input logic [4:0]        ctrl,
  input logic [1:0]        hit_flags
);
  // R10: a flag only falls after a status write with 1 in its position
  assert_flag0_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hit_flags[0]) |-> $past(reg_wr && reg_sel == 2'd1 && reg_wdata[0]));
  assert_flag1_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hit_flags[1]) |-> $past(reg_wr && reg_sel == 2'd1 && reg_wdata[1]));
  // R7: a new flag requires the unit to have been armed
  assert_rise_needs_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit_flags & ~$past(hit_flags))) |-> $past(ctrl[2]));
  // R3: a new flag requires some access strobe on the previous cycle
  assert_rise_needs_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit_flags & ~$past(hit_flags))) |-> $past(bus_rd || bus_wr || fetch_vld));
  // R8: in range mode a hit leaves both flags set
  assert_range_sets_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl[4]) && (|(hit_flags & ~$past(hit_flags)))) |-> (&hit_flags));
endmodule

bind brk_watch_unit brk_watch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .fetch_vld(fetch_vld), .ctrl(ctrl_q), .hit_flags(hit_flags)
);

// File: tb/brk_watch_unit_bench.sv
module brk_watch_unit_bench;
  localparam int AW = 16;
  localparam logic [15:0] A_LO = 16'h1234;
  localparam logic [15:0] A_HI = 16'h1240;

  typedef struct packed {
    logic [15:0] ctrl;
    logic [1:0]  kind;   // 0 read, 1 write, 2 fetch
    logic [15:0] addr;
    logic [1:0]  exp_r;  // flags with range support
    logic [1:0]  exp_n;  // flags without range support
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{16'h0005, 2'd0, 16'h1234, 2'b01, 2'b01}, // R3 read at A
    '{16'h0005, 2'd0, 16'h1240, 2'b10, 2'b10}, // R3 read at B
    '{16'h0005, 2'd0, 16'h1235, 2'b01, 2'b01}, // R6 odd byte of A
    '{16'h0005, 2'd1, 16'h1234, 2'b00, 2'b00}, // R3 write ignored
    '{16'h0006, 2'd1, 16'h1241, 2'b10, 2'b10}, // R4 R6 write odd byte of B
    '{16'h0006, 2'd0, 16'h1240, 2'b00, 2'b00}, // R4 read ignored
    '{16'h000C, 2'd2, 16'h1234, 2'b01, 2'b01}, // R5 fetch at A
    '{16'h000C, 2'd0, 16'h1234, 2'b00, 2'b00}, // R5 read ignored
    '{16'h000B, 2'd0, 16'h1234, 2'b00, 2'b00}, // R7 not armed
    '{16'h001F, 2'd0, 16'h1238, 2'b11, 2'b00}, // R8 R9 inside range
    '{16'h001F, 2'd1, 16'h1234, 2'b11, 2'b01}, // R8 R9 lower bound
    '{16'h001F, 2'd2, 16'h1241, 2'b11, 2'b10}, // R8 R9 R6 upper bound odd
    '{16'h001F, 2'd0, 16'h1242, 2'b00, 2'b00}, // R8 above range
    '{16'h001F, 2'd0, 16'h1232, 2'b00, 2'b00}, // R8 below range
    '{16'h0015, 2'd2, 16'h1238, 2'b00, 2'b00}  // R8 fetch not enabled
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_sel = 2'd0;
  logic [AW-1:0] reg_wdata = '0;
  logic          bus_rd = 1'b0, bus_wr = 1'b0, fetch_vld = 1'b0;
  logic [AW-1:0] bus_addr = '0, fetch_addr = '0;
  logic [AW-1:0] rdata_r, rdata_n;
  logic [1:0]    flags_r, flags_n;
  logic          halt_r, halt_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  brk_watch_unit #(.ADDR_W(AW), .RANGE_EN(1)) u_brk_watch_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_r), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .fetch_vld(fetch_vld),
    .fetch_addr(fetch_addr), .hit_flags(flags_r), .halt_req(halt_r)
  );

  brk_watch_unit #(.ADDR_W(AW), .RANGE_EN(0)) u_brk_watch_unit_nr (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_n), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .fetch_vld(fetch_vld),
    .fetch_addr(fetch_addr), .hit_flags(flags_n), .halt_req(halt_n)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_sel(input logic [1:0] sel);
    reg_sel = sel;
    #1;
  endtask

  task automatic access(input logic [1:0] kind, input logic [15:0] addr);
    @(negedge clk);
    bus_addr = addr; fetch_addr = addr;
    bus_rd = (kind == 2'd0); bus_wr = (kind == 2'd1); fetch_vld = (kind == 2'd2);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; fetch_vld = 1'b0;
    bus_addr = 16'h0000; fetch_addr = 16'h0000;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd_sel(2'(s));
      chk("R1 reset register", rdata_r, 16'h0000);
    end
    chk("R1 reset flags", 16'(flags_r), 16'h0000);
    chk("R1 reset halt", 16'(halt_r), 16'h0000);
    rst_n = 1'b1;

    // R2 register access and readback
    wr_reg(2'd2, 16'hABCD);
    rd_sel(2'd2); chk("R2 address A readback", rdata_r, 16'hABCD);
    wr_reg(2'd0, 16'hFFFF);
    rd_sel(2'd0); chk("R2 control readback", rdata_r, 16'h001F);
    chk("R9 range bit reads 0", rdata_n, 16'h000F);
    wr_reg(2'd0, 16'h0000);
    wr_reg(2'd2, A_LO);
    wr_reg(2'd3, A_HI);
    rd_sel(2'd3); chk("R2 address B readback", rdata_r, A_HI);

    // Table walk: R3 R4 R5 R6 R7 R8 R9 R11
    for (int v = 0; v < NV; v++) begin
      wr_reg(2'd1, 16'h0003);
      wr_reg(2'd0, VEC[v].ctrl);
      access(VEC[v].kind, VEC[v].addr);
      rd_sel(2'd1);
      chk($sformatf("vector %0d flags (range build)", v), rdata_r, 16'(VEC[v].exp_r));
      chk($sformatf("vector %0d flags (no range build)", v), rdata_n, 16'(VEC[v].exp_n));
      chk($sformatf("R11 vector %0d halt", v), 16'(halt_r), 16'(|VEC[v].exp_r));
      chk($sformatf("R11 vector %0d halt no range", v), 16'(halt_n), 16'(|VEC[v].exp_n));
    end

    // R10 stickiness and write-one-to-clear
    wr_reg(2'd1, 16'h0003);
    wr_reg(2'd0, 16'h0005);
    access(2'd0, A_LO);
    access(2'd0, 16'h2000);
    rd_sel(2'd1); chk("R10 flag stays after miss", rdata_r, 16'h0001);
    wr_reg(2'd1, 16'h0002);
    rd_sel(2'd1); chk("R10 clear of other bit keeps flag", rdata_r, 16'h0001);
    wr_reg(2'd1, 16'h0001);
    rd_sel(2'd1); chk("R10 write one clears", rdata_r, 16'h0000);

    // R10 hit and clear in the same cycle: flag stays set
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 16'h0001;
    bus_rd = 1'b1; bus_addr = A_LO;
    @(negedge clk);
    reg_wr = 1'b0; bus_rd = 1'b0; bus_addr = 16'h0000;
    rd_sel(2'd1); chk("R10 hit wins over clear", rdata_r, 16'h0001);

    // R11 disarm drops halt, keeps flags; re-arm restores it
    chk("R11 halt while armed", 16'(halt_r), 16'h0001);
    wr_reg(2'd0, 16'h0001);
    chk("R11 halt low when disarmed", 16'(halt_r), 16'h0000);
    chk("R11 flags kept when disarmed", 16'(flags_r), 16'h0001);
    wr_reg(2'd0, 16'h0005);
    chk("R11 halt back when re-armed", 16'(halt_r), 16'h0001);

    // R7 disarmed write of a matching address leaves flag B clear
    wr_reg(2'd1, 16'h0003);
    wr_reg(2'd0, 16'h0002);
    access(2'd1, A_HI);
    chk("R7 no flag while disarmed", 16'(flags_r), 16'h0000);

    finish_run();
  end
endmodule